// File: doc/BRIEF.md
# Per-Lane Bit-Field Multishift Extractor

This unit fills every byte of a result vector with an 8-bit window taken from a 64-bit lane of a data vector. The window's starting bit comes from the control byte at the same position as the result byte. Bit addressing wraps circularly inside the lane, so a window that starts near the top of the lane continues from its bottom bit. A result byte only ever reads the lane that contains its own byte index, so no bits move between lanes. In effect, result byte i is the low eight bits of data lane i/8 after that lane is rotated right by the low six bits of control byte i.

The data operand can be a full vector, or a single 64-bit value that is copied into every lane. The vector length can be 128, 256 or 512 bits, and result bytes at or above the selected length are forced to zero. An optional per-byte mask picks, for each unselected byte, one of two behaviours: it keeps the byte from a supplied prior-value vector (merge), or it clears the byte (zeroing).

The result is registered. It appears one clock after an input strobe, together with a valid pulse. While no strobe arrives, the result holds its value.

Top module: `bitfield_mshift`

## Requirements
- R1: When no mask is enabled and the length is 512 bits, result byte i equals bits [7:0] of data lane floor(i/8) rotated right by (control byte i AND 63).
- R2: Bit addressing wraps modulo 64. For an offset of 57 to 63, the window takes the lane's top bits and then continues from bit 0 of the same lane. Offset 0 yields lane bits [7:0], and offset 56 yields lane bits [63:56].
- R3: Bits [7:6] of every control byte have no effect on the result.
- R4: A result byte depends only on the 64-bit data lane that holds its own index. Changing any other lane leaves it unchanged.
- R5: When bcast_en is 1, data_vec[63:0] is used as every lane and data_vec[511:64] has no effect.
- R6: len_mode selects the length: 2'b00 is 128 bits, 2'b01 is 256 bits, and 2'b10 or 2'b11 is 512 bits. Result bytes at or above the length are zero, whatever the mask and merge inputs are.
- R7: When mask_en is 1 and zero_mode is 0, an active byte whose byte_mask bit is 0 takes the matching byte of merge_vec.
- R8: When mask_en is 1 and zero_mode is 1, an active byte whose byte_mask bit is 0 becomes zero.
- R9: When mask_en is 0, byte_mask, zero_mode and merge_vec have no effect.
- R10: After reset, out_valid is 0 and result is 0. out_valid is 1 exactly in the cycle after a cycle with in_valid set, and result is updated at that same edge.
- R11: In a cycle without in_valid, result keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| ctrl_vec | input | 512 | Control bytes; low six bits give the start bit |
| data_vec | input | 512 | Data lanes, or the broadcast value in bits [63:0] |
| bcast_en | input | 1 | Copy data_vec[63:0] into every lane |
| len_mode | input | 2 | Vector length select |
| mask_en | input | 1 | Enable per-byte masking |
| zero_mode | input | 1 | 1 clears unselected bytes, 0 merges them |
| byte_mask | input | 64 | Per-byte select, 1 means write the computed byte |
| merge_vec | input | 512 | Prior values used for merge |
| out_valid | output | 1 | Result strobe |
| result | output | 512 | Registered result vector |

## Verification
The masking stage and the length zeroing both act on the same byte in the same cycle. The bench provokes this with merge masking enabled, a nonzero merge vector and mask bits cleared across the length boundary, in each length mode. It then judges that bytes above the length are zero while bytes below it take merge data. Broadcast is also combined with wrap-around offsets, so that the replicated lane and the circular addressing meet in one operation.

// File: rtl/mshift_pkg.sv
package mshift_pkg;

   typedef enum logic [1:0] {
      LEN_128  = 2'b00,
      LEN_256  = 2'b01,
      LEN_512  = 2'b10,
      LEN_512W = 2'b11
   } len_mode_e;

   localparam int unsigned MIN_LEN_BYTES = 16;

   // number of result bytes enabled by a length code, capped by the build size
   function automatic int unsigned active_bytes(input logic [1:0] mode,
                                                input int unsigned max_bytes);
      int unsigned n;
      case (len_mode_e'(mode))
         LEN_128: n = MIN_LEN_BYTES;
         LEN_256: n = MIN_LEN_BYTES * 2;
         default: n = MIN_LEN_BYTES * 4;
      endcase
      return (n > max_bytes) ? max_bytes : n;
   endfunction

endpackage

// File: rtl/mshift_lane_src.sv
module mshift_lane_src #(
   parameter int unsigned LANE_BITS = 64,
   parameter int unsigned NUM_LANES = 8
) (
   input  logic [NUM_LANES*LANE_BITS-1:0]        data_vec,
   input  logic                                  bcast_en,
   output logic [NUM_LANES-1:0][LANE_BITS-1:0]   lanes
);

   genvar j;
   generate
      for (j = 0; j < NUM_LANES; j++) begin : g_lane
         if (j == 0) begin : g_base
            assign lanes[j] = data_vec[LANE_BITS-1:0];
         end else begin : g_rep
            assign lanes[j] = bcast_en ? data_vec[LANE_BITS-1:0]
                                       : data_vec[j*LANE_BITS +: LANE_BITS];
         end
      end
   endgenerate

endmodule

// File: rtl/mshift_byte_sel.sv
module mshift_byte_sel #(
   parameter int unsigned LANE_BITS = 64,
   parameter int unsigned BYTE_BITS = 8
) (
   input  logic [LANE_BITS-1:0] lane_in,
   input  logic [BYTE_BITS-1:0] ctrl_in,
   output logic [BYTE_BITS-1:0] win_out
);

   localparam int unsigned OFF_W = $clog2(LANE_BITS);

   logic [OFF_W-1:0] off;
   assign off = ctrl_in[OFF_W-1:0];

   // one full-lane selector per output bit; the sum wraps in OFF_W bits
   genvar k;
   generate
      for (k = 0; k < BYTE_BITS; k++) begin : g_bit
         logic [OFF_W-1:0] idx;
         assign idx        = off + OFF_W'(k);
         assign win_out[k] = lane_in[idx];
      end
   endgenerate

endmodule

// File: rtl/mshift_mask_stage.sv
module mshift_mask_stage
   import mshift_pkg::*;
#(
   parameter int unsigned BYTE_BITS = 8,
   parameter int unsigned NUM_BYTES = 64
) (
   input  logic [NUM_BYTES*BYTE_BITS-1:0] raw_vec,
   input  logic [NUM_BYTES*BYTE_BITS-1:0] merge_vec,
   input  logic [NUM_BYTES-1:0]           byte_mask,
   input  logic                           mask_en,
   input  logic                           zero_mode,
   input  logic [1:0]                     len_mode,
   output logic [NUM_BYTES*BYTE_BITS-1:0] out_vec
);

   int unsigned n_active;
   assign n_active = active_bytes(len_mode, NUM_BYTES);

   genvar i;
   generate
      for (i = 0; i < NUM_BYTES; i++) begin : g_byte
         logic in_len;
         logic take;
         assign in_len = (i < n_active);
         assign take   = !mask_en || byte_mask[i];
         always_comb begin
            if (!in_len)
               out_vec[i*BYTE_BITS +: BYTE_BITS] = '0;
            else if (take)
               out_vec[i*BYTE_BITS +: BYTE_BITS] = raw_vec[i*BYTE_BITS +: BYTE_BITS];
            else if (zero_mode)
               out_vec[i*BYTE_BITS +: BYTE_BITS] = '0;
            else
               out_vec[i*BYTE_BITS +: BYTE_BITS] = merge_vec[i*BYTE_BITS +: BYTE_BITS];
         end
      end
   endgenerate

endmodule

// File: rtl/bitfield_mshift.sv
module bitfield_mshift
   import mshift_pkg::*;
#(
   parameter int unsigned MAX_BITS  = 512,
   parameter int unsigned LANE_BITS = 64,
   parameter int unsigned BYTE_BITS = 8
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              in_valid,
   input  logic [MAX_BITS-1:0]               ctrl_vec,
   input  logic [MAX_BITS-1:0]               data_vec,
   input  logic                              bcast_en,
   input  logic [1:0]                        len_mode,
   input  logic                              mask_en,
   input  logic                              zero_mode,
   input  logic [MAX_BITS/BYTE_BITS-1:0]     byte_mask,
   input  logic [MAX_BITS-1:0]               merge_vec,
   output logic                              out_valid,
   output logic [MAX_BITS-1:0]               result
);

   localparam int unsigned NUM_BYTES      = MAX_BITS / BYTE_BITS;
   localparam int unsigned NUM_LANES      = MAX_BITS / LANE_BITS;
   localparam int unsigned BYTES_PER_LANE = LANE_BITS / BYTE_BITS;
   localparam int unsigned MIN_LEN_BITS   = MIN_LEN_BYTES * BYTE_BITS;

   generate
      if ((LANE_BITS & (LANE_BITS - 1)) != 0) begin : g_chk_pow2
         $error("LANE_BITS must be a power of two");
      end
      if (MAX_BITS % LANE_BITS != 0 || LANE_BITS % BYTE_BITS != 0) begin : g_chk_div
         $error("MAX_BITS, LANE_BITS and BYTE_BITS must divide evenly");
      end
      if (MAX_BITS < MIN_LEN_BITS) begin : g_chk_min
         $error("MAX_BITS below the shortest length mode");
      end
      if ((1 << $clog2(LANE_BITS)) > (1 << BYTE_BITS)) begin : g_chk_ctrl
         $error("control byte too narrow to address a lane");
      end
   endgenerate

   logic [NUM_LANES-1:0][LANE_BITS-1:0] lanes;
   logic [MAX_BITS-1:0]                 raw_vec;
   logic [MAX_BITS-1:0]                 masked_vec;

   mshift_lane_src #(
      .LANE_BITS(LANE_BITS),
      .NUM_LANES(NUM_LANES)
   ) lane_src_i (
      .data_vec(data_vec),
      .bcast_en(bcast_en),
      .lanes   (lanes)
   );

   genvar b;
   generate
      for (b = 0; b < NUM_BYTES; b++) begin : g_sel
         mshift_byte_sel #(
            .LANE_BITS(LANE_BITS),
            .BYTE_BITS(BYTE_BITS)
         ) byte_sel_i (
            .lane_in(lanes[b / BYTES_PER_LANE]),
            .ctrl_in(ctrl_vec[b*BYTE_BITS +: BYTE_BITS]),
            .win_out(raw_vec[b*BYTE_BITS +: BYTE_BITS])
         );
      end
   endgenerate

   mshift_mask_stage #(
      .BYTE_BITS(BYTE_BITS),
      .NUM_BYTES(NUM_BYTES)
   ) mask_stage_i (
      .raw_vec  (raw_vec),
      .merge_vec(merge_vec),
      .byte_mask(byte_mask),
      .mask_en  (mask_en),
      .zero_mode(zero_mode),
      .len_mode (len_mode),
      .out_vec  (masked_vec)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid)
            result <= masked_vec;
      end
   end

   assert_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(result));

   assert_len_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && len_mode == 2'b00) |=> ((result >> MIN_LEN_BITS) == '0));

   assert_zeroing_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mask_en && zero_mode && byte_mask == '0) |=> (result == '0));

   assert_lane0_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !mask_en && ctrl_vec[BYTE_BITS-1:0] == '0)
      |=> (result[BYTE_BITS-1:0] == $past(data_vec[BYTE_BITS-1:0])));

endmodule

// File: tb/bitfield_mshift_tb_top.sv
module bitfield_mshift_tb_top;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [511:0] ctrl_vec = '0;
   logic [511:0] data_vec = '0;
   logic         bcast_en = 1'b0;
   logic [1:0]   len_mode = 2'b10;
   logic         mask_en = 1'b0;
   logic         zero_mode = 1'b0;
   logic [63:0]  byte_mask = '0;
   logic [511:0] merge_vec = '0;
   logic         out_valid;
   logic [511:0] result;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   bitfield_mshift dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ctrl_vec(ctrl_vec),
      .data_vec(data_vec), .bcast_en(bcast_en), .len_mode(len_mode),
      .mask_en(mask_en), .zero_mode(zero_mode), .byte_mask(byte_mask),
      .merge_vec(merge_vec), .out_valid(out_valid), .result(result)
   );

   function automatic logic [63:0] rotr(input logic [63:0] v, input int s);
      if (s == 0) return v;
      return (v >> s) | (v << (64 - s));
   endfunction

   function automatic logic [511:0] model();
      logic [511:0] r;
      int nb;
      nb = (len_mode == 2'b00) ? 16 : (len_mode == 2'b01) ? 32 : 64;
      r = '0;
      for (int i = 0; i < 64; i++) begin
         logic [63:0] ln;
         logic [7:0]  v;
         ln = bcast_en ? data_vec[63:0] : data_vec[(i/8)*64 +: 64];
         v  = rotr(ln, int'(ctrl_vec[i*8 +: 8]) % 64) & 64'hFF;
         if (i >= nb) v = 8'h00;
         else if (mask_en && !byte_mask[i]) v = zero_mode ? 8'h00 : merge_vec[i*8 +: 8];
         r[i*8 +: 8] = v;
      end
      return r;
   endfunction

   function automatic logic [511:0] pattern(input int seed);
      logic [511:0] p;
      for (int j = 0; j < 8; j++)
         p[j*64 +: 64] = (64'(seed + 1) * 64'h9E3779B97F4A7C15) ^ (64'(j) * 64'hD1B54A32D192ED03)
                         ^ {32'(seed), 32'(~j)};
      return p;
   endfunction

   task automatic chk(input string tag, input logic [511:0] got, input logic [511:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   // inputs already set at a negedge; strobe, then sample at the following negedge
   task automatic fire();
      in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic fill_ctrl(input int off);
      for (int i = 0; i < 64; i++) ctrl_vec[i*8 +: 8] = 8'(off);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 reset out_valid", 512'(out_valid), 512'd0);
      chk("R10 reset result", result, '0);

      // R2: offset 0, 56 and every wrap offset 57..63
      for (int k = 0; k < 9; k++) begin
         int off;
         off = (k == 0) ? 0 : 55 + k;
         fill_ctrl(off);
         data_vec = pattern(k + 100);
         fire();
         chk($sformatf("R2 offset %0d", off), result, model());
      end
      chk("R10 valid pulse", 512'(out_valid), 512'd1);
      @(negedge clk);
      chk("R10 valid drop", 512'(out_valid), 512'd0);

      // R1: sweep of mixed offsets and data
      for (int t = 0; t < 64; t++) begin
         for (int i = 0; i < 64; i++) ctrl_vec[i*8 +: 8] = 8'((t + i * 9) & 63);
         data_vec = pattern(t);
         fire();
         chk($sformatf("R1 sweep %0d", t), result, model());
      end

      // R3: upper control bits ignored
      begin
         logic [511:0] clean;
         for (int i = 0; i < 64; i++) ctrl_vec[i*8 +: 8] = 8'((i * 13) & 63);
         data_vec = pattern(7);
         fire();
         clean = result;
         for (int i = 0; i < 64; i++) ctrl_vec[i*8 +: 8] = 8'(((i * 13) & 63) | ((i & 3) << 6) | 8'h40);
         fire();
         chk("R3 upper ctrl bits", result, clean);
      end

      // R4: lane confinement
      begin
         logic [63:0] lane0;
         lane0 = result[63:0];
         data_vec[511:64] = ~data_vec[511:64];
         fire();
         chk("R4 other lanes changed", 512'(result[63:0]), 512'(lane0));
         chk("R4 full model", result, model());
      end

      // R5: broadcast, combined with wrap offsets
      for (int t = 0; t < 4; t++) begin
         logic [511:0] first;
         bcast_en = 1'b1;
         for (int i = 0; i < 64; i++) ctrl_vec[i*8 +: 8] = 8'(57 + ((i + t) % 7));
         data_vec = pattern(200 + t);
         fire();
         chk($sformatf("R5 broadcast %0d", t), result, model());
         first = result;
         data_vec[511:64] = pattern(300 + t)[511:64];
         fire();
         chk($sformatf("R5 upper data ignored %0d", t), result, first);
      end
      bcast_en = 1'b0;

      // R6 with merge masking across the length boundary
      for (int m = 0; m < 4; m++) begin
         len_mode  = 2'(m);
         mask_en   = 1'b1;
         zero_mode = 1'b0;
         byte_mask = 64'hA5A5_0F0F_3C3C_F0F0;
         merge_vec = pattern(400 + m);
         for (int i = 0; i < 64; i++) ctrl_vec[i*8 +: 8] = 8'((i * 5 + m) & 63);
         data_vec = pattern(500 + m);
         fire();
         chk($sformatf("R6 R7 length mode %0d", m), result, model());
      end
      len_mode = 2'b00;
      mask_en = 1'b0;
      fire();
      chk("R6 upper zero unmasked", result >> 128, '0);
      len_mode = 2'b10;

      // R7 merge
      mask_en = 1'b1; zero_mode = 1'b0; byte_mask = '0; merge_vec = pattern(600);
      fire();
      chk("R7 merge all", result, merge_vec);
      // R8 zeroing
      zero_mode = 1'b1; byte_mask = 64'h00FF_FF00_1234_8001;
      fire();
      chk("R8 zeroing", result, model());
      byte_mask = '0;
      fire();
      chk("R8 zeroing all", result, '0);
      // R9 mask disabled
      begin
         logic [511:0] exp;
         mask_en = 1'b0; zero_mode = 1'b0; byte_mask = '0;
         exp = model();
         merge_vec = pattern(700);
         fire();
         chk("R9 mask ignored", result, exp);
      end

      // R11 hold
      begin
         logic [511:0] held;
         held = result;
         data_vec = pattern(800);
         ctrl_vec = pattern(801);
         repeat (3) @(negedge clk);
         chk("R11 hold result", result, held);
         chk("R11 no strobe", 512'(out_valid), 512'd0);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule